// File: doc/BRIEF.md
# Stallable Pixel Clock Divider

This block derives a display pixel clock from the controller clock. An 8-bit divisor sets the divide ratio. The output is a square wave whose period is 2 × (divisor + 1) controller cycles, so the available range runs from the controller clock divided by 2 down to the controller clock divided by 512.

Alongside the pixel clock level, the block drives one-cycle strobes that mark each rising and falling transition. Downstream line and frame timing logic can act on these strobes without running a second clock domain.

In passive mode, a pixel FIFO underrun freezes the divider. The level and the count are both held, and counting picks up where it stopped once the underrun clears. In active mode the underrun input is ignored and the clock runs without pause. Double-pixel-clock mode requires a divisor of at least 1. If software programs 0 in that mode, the block substitutes 1 and flags the setting as a configuration error.

Top module: `pixclk_div`

## Requirements
- R1: While reset is asserted and in the first cycle after it, pix_clk, pix_rise and pix_fall are all 0.
- R2: With the divisor held at D, pix_clk has a period of exactly 2 × (D + 1) clock cycles for every D from 0 to 255.
- R3: pix_clk is high for exactly D + 1 cycles and low for exactly D + 1 cycles in each period.
- R4: pix_rise is 1 only in the first cycle in which pix_clk is 1 after having been 0. pix_fall is 1 only in the first cycle in which pix_clk is 0 after having been 1. The two strobes are never 1 together.
- R5: In passive mode (passive_mode = 1), every clock edge that samples fifo_underrun = 1 leaves pix_clk and the internal count unchanged and produces no strobe. The period in which the stall occurs is lengthened by exactly the number of stalled cycles.
- R6: In active mode (passive_mode = 0), fifo_underrun has no effect on pix_clk or the strobes.
- R7: When dbl_pix_mode = 1 and the divisor is 0, cfg_err is 1 and the divider behaves as if the divisor were 1 (period 4). In every other case cfg_err is 0.
- R8: A divisor change takes effect only at a falling transition of pix_clk. The period that is under way when the change happens keeps the old length.
- R9: While en = 0, pix_clk and both strobes are 0. After en rises, the first rising strobe appears D + 1 cycles after the first clock edge that samples en = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Divider enable |
| divisor | input | 8 | Divisor D; period is 2 × (D + 1) |
| passive_mode | input | 1 | 1 = passive display (underrun stalls), 0 = active |
| fifo_underrun | input | 1 | Pixel FIFO underrun flag |
| dbl_pix_mode | input | 1 | Double pixel clock mode; forces a minimum divisor of 1 |
| pix_clk | output | 1 | Pixel clock level |
| pix_rise | output | 1 | One-cycle strobe on a rising transition of pix_clk |
| pix_fall | output | 1 | One-cycle strobe on a falling transition of pix_clk |
| cfg_err | output | 1 | Divisor 0 requested while in double pixel clock mode |

## Verification
A wrong count or a wrong stored divisor appears as a phase length that is off by one or more cycles. It becomes visible at the very next strobe, which arrives at most 256 cycles later. A count that keeps moving during a stall shifts the next strobe early by the number of stalled cycles. A divisor register that loads at the wrong time stretches or shrinks the period already under way rather than the one that follows. Both faults therefore show up within a single output period.

// File: rtl/pixclk_div.sv
module pixclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] divisor,
  input  logic             passive_mode,
  input  logic             fifo_underrun,
  input  logic             dbl_pix_mode,
  output logic             pix_clk,
  output logic             pix_rise,
  output logic             pix_fall,
  output logic             cfg_err
);

  localparam logic [DIV_W-1:0] MIN_DBL = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_eff;
  logic             stall;
  logic             hit;

  assign cfg_err = dbl_pix_mode && (divisor == '0);
  assign div_eff = cfg_err ? MIN_DBL : divisor;
  assign stall   = passive_mode && fifo_underrun;
  assign hit     = (cnt_q == div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      div_q    <= '0;
      pix_clk  <= 1'b0;
      pix_rise <= 1'b0;
      pix_fall <= 1'b0;
    end else if (!en) begin
      cnt_q    <= '0;
      div_q    <= div_eff;
      pix_clk  <= 1'b0;
      pix_rise <= 1'b0;
      pix_fall <= 1'b0;
    end else if (stall) begin
      pix_rise <= 1'b0;
      pix_fall <= 1'b0;
    end else if (hit) begin
      cnt_q    <= '0;
      pix_clk  <= ~pix_clk;
      pix_rise <= ~pix_clk;
      pix_fall <= pix_clk;
      if (pix_clk) div_q <= div_eff;
    end else begin
      cnt_q    <= cnt_q + DIV_W'(1);
      pix_rise <= 1'b0;
      pix_fall <= 1'b0;
    end
  end

endmodule

module pixclk_div_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic passive_mode,
  input logic fifo_underrun,
  input logic pix_clk,
  input logic pix_rise,
  input logic pix_fall
);

  // R4
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_rise |-> (pix_clk && !$past(pix_clk)));

  // R4
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_fall |-> (!pix_clk && $past(pix_clk)));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pix_rise, pix_fall}));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && passive_mode && fifo_underrun) |=> ($stable(pix_clk) && !pix_rise && !pix_fall));

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pix_clk && !pix_rise && !pix_fall));

endmodule

bind pixclk_div pixclk_div_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .passive_mode(passive_mode),
  .fifo_underrun(fifo_underrun), .pix_clk(pix_clk),
  .pix_rise(pix_rise), .pix_fall(pix_fall)
);

// File: tb/tb_pixclk_div.sv
module tb_pixclk_div;
  logic clk = 1'b0;
  logic rst_n, en, passive_mode, fifo_underrun, dbl_pix_mode;
  logic [7:0] divisor;
  logic pix_clk, pix_rise, pix_fall, cfg_err;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pixclk_div dut (
    .clk(clk), .rst_n(rst_n), .en(en), .divisor(divisor),
    .passive_mode(passive_mode), .fifo_underrun(fifo_underrun),
    .dbl_pix_mode(dbl_pix_mode), .pix_clk(pix_clk), .pix_rise(pix_rise),
    .pix_fall(pix_fall), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic to_edge(input bit rise, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!(rise ? pix_rise : pix_fall) && n < 2000);
  endtask

  task automatic restart(input logic [7:0] d, input logic pm, input logic dbl);
    en = 1'b0; divisor = d; passive_mode = pm; dbl_pix_mode = dbl; fifo_underrun = 1'b0;
    step(); step();
    en = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; divisor = 8'd3; passive_mode = 1'b0;
    fifo_underrun = 1'b0; dbl_pix_mode = 1'b0;
    step(); step();
    chk("R1 pix_clk in reset", pix_clk, 0);
    chk("R1 strobes in reset", pix_rise | pix_fall, 0);
    rst_n = 1'b1;
    step();
    chk("R1 pix_clk after reset", pix_clk, 0);
  endtask

  task automatic t_period(input logic [7:0] d);
    int n;
    restart(d, 1'b0, 1'b0);
    to_edge(1'b1, n);
    chk("R9 first rise after enable", n, d + 1);
    to_edge(1'b0, n);
    chk("R3 high phase", n, d + 1);
    to_edge(1'b1, n);
    chk("R3 low phase", n, d + 1);
    to_edge(1'b1, n);
    chk("R2 period", n, 2 * (d + 1));
  endtask

  task automatic t_strobe();
    int rises = 0, falls = 0, bad = 0;
    logic prev;
    restart(8'd2, 1'b0, 1'b0);
    prev = pix_clk;
    for (int i = 0; i < 24; i++) begin
      step();
      if (pix_rise) rises++;
      if (pix_fall) falls++;
      if (pix_rise != (pix_clk && !prev)) bad++;
      if (pix_fall != (!pix_clk && prev)) bad++;
      prev = pix_clk;
    end
    chk("R4 strobe alignment errors", bad, 0);
    chk("R4 rises in 24 cycles", rises, 4);
    chk("R4 falls in 24 cycles", falls, 4);
  endtask

  task automatic t_stall();
    int n, moved = 0, strobes = 0;
    restart(8'd3, 1'b1, 1'b0);
    to_edge(1'b1, n);
    fifo_underrun = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      if (pix_clk != 1'b1) moved++;
      if (pix_rise || pix_fall) strobes++;
    end
    chk("R5 level held during stall", moved, 0);
    chk("R5 no strobes during stall", strobes, 0);
    fifo_underrun = 1'b0;
    to_edge(1'b0, n);
    chk("R5 remaining high phase after stall", n, 4);
  endtask

  task automatic t_active();
    int n;
    restart(8'd3, 1'b0, 1'b0);
    fifo_underrun = 1'b1;
    to_edge(1'b1, n);
    chk("R6 first rise with underrun in active", n, 4);
    to_edge(1'b1, n);
    chk("R6 period with underrun in active", n, 8);
    fifo_underrun = 1'b0;
  endtask

  task automatic t_dbl();
    int n;
    restart(8'd0, 1'b0, 1'b1);
    step();
    chk("R7 cfg_err dbl div0", cfg_err, 1);
    to_edge(1'b1, n);
    to_edge(1'b1, n);
    chk("R7 period dbl div0", n, 4);
    restart(8'd3, 1'b0, 1'b1);
    step();
    chk("R7 cfg_err dbl div3", cfg_err, 0);
    restart(8'd0, 1'b0, 1'b0);
    step();
    chk("R7 cfg_err no dbl div0", cfg_err, 0);
    to_edge(1'b1, n);
    to_edge(1'b1, n);
    chk("R7 period no dbl div0", n, 2);
  endtask

  task automatic t_change();
    int n;
    restart(8'd5, 1'b0, 1'b0);
    to_edge(1'b0, n);
    step(); step();
    divisor = 8'd2;
    to_edge(1'b0, n);
    chk("R8 old period kept", n, 10);
    to_edge(1'b0, n);
    chk("R8 new period", n, 6);
  endtask

  task automatic t_disable();
    int hi = 0;
    restart(8'd4, 1'b0, 1'b0);
    repeat (7) step();
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (pix_clk || pix_rise || pix_fall) hi++;
    end
    chk("R9 outputs low while disabled", hi, 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_period(8'd0);
    t_period(8'd3);
    t_period(8'd7);
    t_period(8'd255);
    t_strobe();
    t_stall();
    t_active();
    t_dbl();
    t_change();
    t_disable();
    done = 1'b1;
    report();
    $finish;
  end
endmodule